// File: doc/BRIEF.md
# Decode-Stage Operand Bypass with Register File

This block holds the eight architectural registers of a five-stage in-order pipeline. It also supplies the two source operands that the decode stage needs. Each decode source identifier is compared against the destinations of the instructions still in flight: the one in execute, the ALU result and the loaded value in the memory stage, and the one in write-back. The newest matching result goes to the operand output. Only when nothing matches does the register-file copy, which may be stale, get through. The operands are therefore correct by the end of decode, without waiting for the producer to retire.

Write-back drives the single write port, and the register array takes the new value on the rising clock edge. In the cycle before that edge, a reader of the same register still gets the value, because the write-back stage takes part in the bypass. Any identifier of 8 or above is a "no register" code. It reads as zero, it is never written, and it never matches a producer. A load that is still in execute has no data yet. For a dependent reader, the block raises a hazard flag that external stall logic can use, and it does not forward from that load.

Top module: `dec_fwd_unit`

## Requirements
- R1: After a synchronous active-low reset, every register 0..7 reads as zero.
- R2: A source identifier of 8 or above (8 is the canonical "no register" code) yields an operand of zero, whatever any producer holds.
- R3: A write-back with enable high and identifier 0..7 is committed on the rising clock edge. From the next cycle the register array alone returns it.
- R4: A write-back with enable low, or with an identifier of 8 or above, leaves every register unchanged.
- R5: A non-load execute-stage producer whose destination equals the source wins over every older stage.
- R6: Below execute, the order of precedence is memory-stage ALU result, then memory-stage load result, then write-back value, then register array.
- R7: A write-back value is forwarded combinationally in the same cycle it is presented, before it is committed.
- R8: A producer matches only if its write enable is high. A producer with enable low is skipped in favour of the next stage.
- R9: If the execute stage holds a load (load flag high, enable high) whose destination 0..7 equals either source, `load_use_hazard` is high in that same cycle. That source then takes its value from the older stages, as if execute held nothing.
- R10: Both source ports resolve independently within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_a_id | input | 4 | First decode source identifier |
| src_b_id | input | 4 | Second decode source identifier |
| ex_dst_id | input | 4 | Execute-stage destination identifier |
| ex_wen | input | 1 | Execute-stage write enable |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_result | input | 32 | Execute-stage ALU result |
| mem_alu_dst_id | input | 4 | Memory-stage ALU destination identifier |
| mem_alu_wen | input | 1 | Memory-stage ALU write enable |
| mem_alu_val | input | 32 | Memory-stage ALU result |
| mem_ld_dst_id | input | 4 | Memory-stage load destination identifier |
| mem_ld_wen | input | 1 | Memory-stage load write enable |
| mem_ld_val | input | 32 | Memory-stage loaded data |
| wb_dst_id | input | 4 | Write-back destination identifier (write port) |
| wb_wen | input | 1 | Write-back enable |
| wb_val | input | 32 | Write-back data |
| opnd_a | output | 32 | Resolved first operand |
| opnd_b | output | 32 | Resolved second operand |
| load_use_hazard | output | 1 | Execute-stage load feeds a decode source |

## Verification
The operands and the hazard flag are combinational, so they are due in the same cycle as the identifiers and producer fields that cause them. The bench drives each vector on the falling edge and samples two nanoseconds later, well before the next rising edge. A write-back becomes visible through the register array alone one rising edge after it is presented. The vector table relies on this when a later row reads a register with no producer in flight. A reference array of architectural state in the bench is updated at each of those edges, and the final sweep of all registers is compared against it.

// File: rtl/dfu_pkg.sv
// Shared definitions for the decode-stage operand bypass.
// Assumes: identifiers at or above the register count mean "no register".
package dfu_pkg;

    // Which stage supplied an operand, in descending precedence.
    typedef enum logic [2:0] {
        SRC_EX      = 3'd0,
        SRC_MEM_ALU = 3'd1,
        SRC_MEM_LD  = 3'd2,
        SRC_WB      = 3'd3,
        SRC_RF      = 3'd4,
        SRC_NONE    = 3'd5
    } fwd_src_e;

    // Canonical "no register" identifier.
    localparam logic [3:0] NO_REG_ID = 4'd8;

endpackage

// File: rtl/fwd_regfile.sv
// Architectural register array: two combinational reads and one write
// that is committed on the rising clock edge.
// Assumes: a read or write identifier >= REG_COUNT performs no access.
module fwd_regfile #(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 8,
    parameter int ID_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   rd_a_id,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_a_val,
    output logic [DATA_W-1:0] rd_b_val,
    input  logic [ID_W-1:0]   wr_id,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val
);
    localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(REG_COUNT);

    logic [DATA_W-1:0] regs [REG_COUNT];

    // One storage word per register, each with its own write decode.
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_word
        // Clear on reset, otherwise load when this word is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_id < LIMIT && wr_id[IDX_W-1:0] == IDX_W'(g))
                regs[g] <= wr_val;
        end
    end

    // Read ports: invalid identifiers return zero.
    always_comb begin
        rd_a_val = (rd_a_id < LIMIT) ? regs[rd_a_id[IDX_W-1:0]] : '0;
        rd_b_val = (rd_b_id < LIMIT) ? regs[rd_b_id[IDX_W-1:0]] : '0;
    end
endmodule

// File: rtl/fwd_select.sv
// Per-source bypass selector: picks the youngest valid producer whose
// destination equals the source, else the register-array value.
// Assumes: a load in execute has no data; it flags a stall instead.
module fwd_select #(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 8,
    parameter int ID_W      = 4
) (
    input  logic [ID_W-1:0]   src_id,
    input  logic [ID_W-1:0]   ex_dst_id,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [DATA_W-1:0] ex_result,
    input  logic [ID_W-1:0]   mem_alu_dst_id,
    input  logic              mem_alu_wen,
    input  logic [DATA_W-1:0] mem_alu_val,
    input  logic [ID_W-1:0]   mem_ld_dst_id,
    input  logic              mem_ld_wen,
    input  logic [DATA_W-1:0] mem_ld_val,
    input  logic [ID_W-1:0]   wb_dst_id,
    input  logic              wb_wen,
    input  logic [DATA_W-1:0] wb_val,
    input  logic [DATA_W-1:0] rf_val,
    output logic [DATA_W-1:0] operand,
    output logic              stall_req
);
    import dfu_pkg::*;

    localparam logic [ID_W-1:0] LIMIT = ID_W'(REG_COUNT);

    logic     src_real;
    logic     hit_ex, hit_ma, hit_ml, hit_wb;
    fwd_src_e pick;

    // Compare the source against each producer's destination.
    always_comb begin
        src_real  = src_id < LIMIT;
        hit_ex    = src_real && ex_wen && (ex_dst_id == src_id);
        hit_ma    = src_real && mem_alu_wen && (mem_alu_dst_id == src_id);
        hit_ml    = src_real && mem_ld_wen && (mem_ld_dst_id == src_id);
        hit_wb    = src_real && wb_wen && (wb_dst_id == src_id);
        stall_req = hit_ex && ex_is_load;
    end

    // Choose the supplying stage by precedence.
    always_comb begin
        if (!src_real)                 pick = SRC_NONE;
        else if (hit_ex && !ex_is_load) pick = SRC_EX;
        else if (hit_ma)               pick = SRC_MEM_ALU;
        else if (hit_ml)               pick = SRC_MEM_LD;
        else if (hit_wb)               pick = SRC_WB;
        else                           pick = SRC_RF;
    end

    // Route the chosen value to the operand.
    always_comb begin
        unique case (pick)
            SRC_EX:      operand = ex_result;
            SRC_MEM_ALU: operand = mem_alu_val;
            SRC_MEM_LD:  operand = mem_ld_val;
            SRC_WB:      operand = wb_val;
            SRC_RF:      operand = rf_val;
            default:     operand = '0;
        endcase
    end
endmodule

// File: rtl/dec_fwd_unit.sv
// Decode-stage operand bypass: register array plus one bypass selector
// per source port; ORs the per-port load-use requests into one flag.
// Assumes: the write-back stage drives the array's only write port.
module dec_fwd_unit #(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 8,
    parameter int ID_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   src_a_id,
    input  logic [ID_W-1:0]   src_b_id,
    input  logic [ID_W-1:0]   ex_dst_id,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [DATA_W-1:0] ex_result,
    input  logic [ID_W-1:0]   mem_alu_dst_id,
    input  logic              mem_alu_wen,
    input  logic [DATA_W-1:0] mem_alu_val,
    input  logic [ID_W-1:0]   mem_ld_dst_id,
    input  logic              mem_ld_wen,
    input  logic [DATA_W-1:0] mem_ld_val,
    input  logic [ID_W-1:0]   wb_dst_id,
    input  logic              wb_wen,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              load_use_hazard
);
    localparam int PORTS = 2;

    logic [ID_W-1:0]   src_ids  [PORTS];
    logic [DATA_W-1:0] rf_vals  [PORTS];
    logic [DATA_W-1:0] opnds    [PORTS];
    logic [PORTS-1:0]  stalls;

    // Gather the source identifiers into a port-indexed array.
    always_comb begin
        src_ids[0] = src_a_id;
        src_ids[1] = src_b_id;
    end

    fwd_regfile #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .ID_W(ID_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_id  (src_a_id),
        .rd_b_id  (src_b_id),
        .rd_a_val (rf_vals[0]),
        .rd_b_val (rf_vals[1]),
        .wr_id    (wb_dst_id),
        .wr_en    (wb_wen),
        .wr_val   (wb_val)
    );

    // One bypass selector per read port.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        fwd_select #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .ID_W(ID_W)) u_sel (
            .src_id         (src_ids[p]),
            .ex_dst_id      (ex_dst_id),
            .ex_wen         (ex_wen),
            .ex_is_load     (ex_is_load),
            .ex_result      (ex_result),
            .mem_alu_dst_id (mem_alu_dst_id),
            .mem_alu_wen    (mem_alu_wen),
            .mem_alu_val    (mem_alu_val),
            .mem_ld_dst_id  (mem_ld_dst_id),
            .mem_ld_wen     (mem_ld_wen),
            .mem_ld_val     (mem_ld_val),
            .wb_dst_id      (wb_dst_id),
            .wb_wen         (wb_wen),
            .wb_val         (wb_val),
            .rf_val         (rf_vals[p]),
            .operand        (opnds[p]),
            .stall_req      (stalls[p])
        );
    end

    // Drive the outputs from the per-port results.
    always_comb begin
        opnd_a          = opnds[0];
        opnd_b          = opnds[1];
        load_use_hazard = |stalls;
    end
endmodule

// File: rtl/dec_fwd_unit_chk.sv
// Property checker for the decode-stage operand bypass, bound to the top.
// Assumes: the top's parameters are passed through by the bind.
module dec_fwd_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 8,
    parameter int ID_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   src_a_id,
    input logic [ID_W-1:0]   src_b_id,
    input logic [ID_W-1:0]   ex_dst_id,
    input logic              ex_wen,
    input logic              ex_is_load,
    input logic [DATA_W-1:0] ex_result,
    input logic [ID_W-1:0]   mem_alu_dst_id,
    input logic              mem_alu_wen,
    input logic [DATA_W-1:0] mem_alu_val,
    input logic [ID_W-1:0]   mem_ld_dst_id,
    input logic              mem_ld_wen,
    input logic [DATA_W-1:0] mem_ld_val,
    input logic [ID_W-1:0]   wb_dst_id,
    input logic              wb_wen,
    input logic [DATA_W-1:0] wb_val,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              load_use_hazard
);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(REG_COUNT);

    logic a_real, a_any_producer;

    // Summarise whether source A has any in-flight producer this cycle.
    always_comb begin
        a_real         = src_a_id < LIMIT;
        a_any_producer = (ex_wen && ex_dst_id == src_a_id)
                      || (mem_alu_wen && mem_alu_dst_id == src_a_id)
                      || (mem_ld_wen && mem_ld_dst_id == src_a_id)
                      || (wb_wen && wb_dst_id == src_a_id);
    end

    p_none_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_id >= LIMIT) |-> (opnd_a == '0));

    p_none_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b_id >= LIMIT) |-> (opnd_b == '0));

    p_ex_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_real && ex_wen && !ex_is_load && ex_dst_id == src_a_id) |-> (opnd_a == ex_result));

    p_ld_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_real && ex_wen && ex_is_load && ex_dst_id == src_a_id) |-> load_use_hazard);

    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_use_hazard |-> (ex_is_load && ex_wen && ex_dst_id < LIMIT));

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wb_wen) && a_real && !a_any_producer
         && $past(wb_dst_id) == src_a_id) |-> (opnd_a == $past(wb_val)));
endmodule

bind dec_fwd_unit dec_fwd_unit_chk #(
    .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .ID_W(ID_W)
) u_chk (.*);

// File: tb/tb_dec_fwd_unit.sv
// Bench: a table of dependent instruction vectors, then directed reset
// and state-sweep checks against a reference register model.
module tb_dec_fwd_unit;
    localparam int DW = 32;
    localparam int RC = 8;
    localparam int IW = 4;

    typedef struct packed {
        logic [3:0]  sa;  logic [3:0] sb;
        logic [3:0]  exd; logic exw; logic exl; logic [31:0] exv;
        logic [3:0]  mad; logic maw; logic [31:0] mav;
        logic [3:0]  mld; logic mlw; logic [31:0] mlv;
        logic [3:0]  wbd; logic wbw; logic [31:0] wbv;
        logic [31:0] ea;  logic [31:0] eb; logic eh;
    } vec_t;

    localparam int NV = 16;
    // Rows mimic add r1,r2,r3 followed by dependent readers, then corners.
    localparam vec_t VEC [NV] = '{
        '{4'd8,4'd8, 4'd0,1'b0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd2,1'b1,32'd5,   32'd0, 32'd0, 1'b0},
        '{4'd2,4'd8, 4'd0,1'b0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd3,1'b1,32'd7,   32'd5, 32'd0, 1'b0},
        '{4'd2,4'd3, 4'd0,1'b0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,   32'd5, 32'd7, 1'b0},
        '{4'd1,4'd3, 4'd1,1'b1,1'b0,32'd12, 4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,   32'd12,32'd7, 1'b0},
        '{4'd1,4'd7, 4'd4,1'b1,1'b0,32'd5,  4'd1,1'b1,32'd12, 4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,   32'd12,32'd0, 1'b0},
        '{4'd1,4'd4, 4'd6,1'b1,1'b0,32'd0,  4'd4,1'b1,32'd5,  4'd0,1'b0,32'd0,  4'd1,1'b1,32'd12,  32'd12,32'd5, 1'b0},
        '{4'd1,4'd6, 4'd8,1'b1,1'b0,32'd99, 4'd6,1'b1,32'd0,  4'd0,1'b0,32'd0,  4'd4,1'b1,32'd5,   32'd12,32'd0, 1'b0},
        '{4'd5,4'd5, 4'd5,1'b1,1'b0,32'd11, 4'd5,1'b1,32'd22, 4'd5,1'b1,32'd33, 4'd5,1'b1,32'd44,  32'd11,32'd11,1'b0},
        '{4'd5,4'd8, 4'd5,1'b0,1'b0,32'd11, 4'd5,1'b1,32'd22, 4'd5,1'b1,32'd33, 4'd5,1'b1,32'd44,  32'd22,32'd0, 1'b0},
        '{4'd5,4'd5, 4'd0,1'b0,1'b0,32'd0,  4'd5,1'b0,32'd22, 4'd5,1'b1,32'd33, 4'd5,1'b1,32'd55,  32'd33,32'd33,1'b0},
        '{4'd5,4'd2, 4'd5,1'b1,1'b1,32'd77, 4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,   32'd55,32'd5, 1'b1},
        '{4'd2,4'd5, 4'd2,1'b1,1'b1,32'd88, 4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd2,1'b1,32'd66,  32'd66,32'd55,1'b1},
        '{4'd8,4'd8, 4'd8,1'b1,1'b1,32'd9,  4'd8,1'b1,32'd9,  4'd0,1'b0,32'd0,  4'd8,1'b1,32'd123, 32'd0, 32'd0, 1'b0},
        '{4'd3,4'd1, 4'd0,1'b0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd3,1'b0,32'd999, 32'd7, 32'd12,1'b0},
        '{4'd3,4'd2, 4'd0,1'b0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,   32'd7, 32'd66,1'b0},
        '{4'd9,4'd15,4'd9,1'b1,1'b0,32'd4,  4'd15,1'b1,32'd4, 4'd0,1'b0,32'd0,  4'd0,1'b0,32'd0,   32'd0, 32'd0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] src_a_id, src_b_id, ex_dst_id, mem_alu_dst_id, mem_ld_dst_id, wb_dst_id;
    logic          ex_wen, ex_is_load, mem_alu_wen, mem_ld_wen, wb_wen;
    logic [DW-1:0] ex_result, mem_alu_val, mem_ld_val, wb_val;
    logic [DW-1:0] opnd_a, opnd_b;
    logic          load_use_hazard;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [DW-1:0] model [RC];

    always #5 clk = ~clk;

    dec_fwd_unit #(.DATA_W(DW), .REG_COUNT(RC), .ID_W(IW)) dut (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        src_a_id = 4'd8; src_b_id = 4'd8;
        ex_dst_id = 4'd8; ex_wen = 1'b0; ex_is_load = 1'b0; ex_result = '0;
        mem_alu_dst_id = 4'd8; mem_alu_wen = 1'b0; mem_alu_val = '0;
        mem_ld_dst_id = 4'd8; mem_ld_wen = 1'b0; mem_ld_val = '0;
        wb_dst_id = 4'd8; wb_wen = 1'b0; wb_val = '0;
    endtask

    // Read every register with nothing in flight and compare to the model.
    task automatic sweep(input string req);
        for (int r = 0; r < RC; r += 2) begin
            @(negedge clk);
            idle();
            src_a_id = IW'(r); src_b_id = IW'(r + 1);
            #2;
            check(req, opnd_a, model[r]);
            check(req, opnd_b, model[r + 1]);
        end
    endtask

    initial begin
        for (int r = 0; r < RC; r++) model[r] = '0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: all registers zero after reset.
        sweep("R1");

        // Table walk: R2 R4 R5 R6 R7 R8 R9 R10 in the row comments above.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            src_a_id = VEC[i].sa; src_b_id = VEC[i].sb;
            ex_dst_id = VEC[i].exd; ex_wen = VEC[i].exw; ex_is_load = VEC[i].exl; ex_result = VEC[i].exv;
            mem_alu_dst_id = VEC[i].mad; mem_alu_wen = VEC[i].maw; mem_alu_val = VEC[i].mav;
            mem_ld_dst_id = VEC[i].mld; mem_ld_wen = VEC[i].mlw; mem_ld_val = VEC[i].mlv;
            wb_dst_id = VEC[i].wbd; wb_wen = VEC[i].wbw; wb_val = VEC[i].wbv;
            #2;
            check($sformatf("R10 R5 R6 R7 R8 R2 row %0d port A", i), opnd_a, VEC[i].ea);
            check($sformatf("R10 R5 R6 R7 R8 R2 row %0d port B", i), opnd_b, VEC[i].eb);
            check($sformatf("R9 row %0d hazard", i), DW'(load_use_hazard), DW'(VEC[i].eh));
            @(posedge clk);
            if (VEC[i].wbw && VEC[i].wbd < IW'(RC)) model[VEC[i].wbd[2:0]] = VEC[i].wbv;
        end

        // R3 R4: committed state matches the model; disabled and ID 8 writes left no trace.
        sweep("R3 R4");

        // R1: reset mid-run clears everything again.
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < RC; r++) model[r] = '0;
        sweep("R1 after second reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule